// File: doc/BRIEF.md
# Entropy Seed Register Unit

This block serves one read-with-write control/status register that hands a processor core raw entropy. Each CSR access is presented for one cycle with a 12-bit address, a write-intent flag, the current privilege mode, a virtualization flag and two per-mode enable bits. In that same cycle the block answers with read data and an exception code. When the address is not its own, it stays silent. Permission checking is combinational. Buffer and health state change only on the clock edge that ends a permitted access.

On the source side, a valid/ready handshake fills a one-entry, 16-bit sample buffer, and a sticky failure input reports a broken noise source. After reset the unit spends a fixed number of cycles in self-test, then waits for samples. Each sample is handed out once: a permitted read that delivers it empties the buffer. Once the failure input is seen, the unit stays in its failed state until reset.

Top module: `entropy_seed_csr`

## Requirements
- R1: Only address 0x015 is decoded. For any other address `hit_o` is 0, `exc_o` is 0, `rdata_o` is 0 and no state changes.
- R2: Read data bits [31:30] carry the health status: 2'b00 self-test, 2'b01 waiting, 2'b10 sample present, 2'b11 failed. Bits [29:16] read as zero.
- R3: With status 2'b10, bits [15:0] hold the buffered sample. With any other status, and whenever an exception is raised, bits [15:0] read as zero.
- R4: An access with `wr_intent_i` low raises illegal instruction. `exc_o` uses 2'd1 for illegal instruction, 2'd2 for the virtual-instruction fault and 2'd0 for success.
- R5: Machine mode (`priv_i` = 2'b11) is granted whenever the feature is enabled and write intent is present, including while virtualization is active.
- R6: Supervisor mode (2'b01) is granted only when `sup_seed_en_i` is 1. User mode (2'b00) is granted only when `usr_seed_en_i` is 1. The reserved mode 2'b10 and every other case raise illegal instruction.
- R7: When `virt_i` is 1 and the mode is not machine, the access raises the virtual-instruction fault if `sup_seed_en_i` is 1 and illegal instruction otherwise. This check overrides R6.
- R8: When `feat_en_i` is 0, every access to the address raises illegal instruction.
- R9: After reset the status is 2'b00 for exactly SELFTEST_CYCLES rising edges, with `src_ready_o` low. After that it becomes 2'b01.
- R10: `src_ready_o` is high only when the buffer is empty, self-test has finished and the unit has not failed. A sample is captured on an edge where both valid and ready are high, and the status then reads 2'b10.
- R11: A granted read that returns status 2'b10 empties the buffer, so the next read returns 2'b01 with zero data until a new sample arrives.
- R12: A high `src_fail_i` moves the status to 2'b11 on the next edge. The status then stays there until reset, the buffered sample is discarded and `src_ready_o` stays low.
- R13: An access that raises an exception does not consume the buffered sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| feat_en_i | input | 1 | Entropy feature enabled |
| req_i | input | 1 | CSR access presented this cycle |
| addr_i | input | 12 | CSR address |
| wr_intent_i | input | 1 | Access form intends to write |
| priv_i | input | 2 | Privilege mode: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization active |
| sup_seed_en_i | input | 1 | Supervisor access enable |
| usr_seed_en_i | input | 1 | User access enable |
| hit_o | output | 1 | Access targets this register |
| exc_o | output | 2 | Exception code (0 none, 1 illegal, 2 virtual fault) |
| rdata_o | output | 32 | Status and sample word |
| src_valid_i | input | 1 | Source sample valid |
| src_data_i | input | 16 | Source sample |
| src_ready_o | output | 1 | Buffer can accept a sample |
| src_fail_i | input | 1 | Source reports unrecoverable failure |

## Verification
The hardest state to reach from the ports is a full buffer that is probed by a long run of rejected accesses and then read by a permitted one. If any rejected access consumed the sample, the failure would only show on that final read. The stimulus fills the buffer with a known pattern and walks through every rejected combination of mode, enable bits, virtualization, write intent and feature enable. It then reads the buffer in a permitted mode and expects the original sample. A second hard point is the exact cycle at which self-test ends. It is reached by counting edges from the release of reset and sampling the status one edge before and one edge after the expected exit.

// File: rtl/seed_csr_pkg.sv
package seed_csr_pkg;

  typedef enum logic [1:0] {
    ST_SELFTEST = 2'b00,
    ST_WAIT     = 2'b01,
    ST_READY    = 2'b10,
    ST_FAILED   = 2'b11
  } seed_stat_e;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_VIRT    = 2'd2
  } seed_exc_e;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  // Permission verdict; checks are ordered by priority.
  function automatic seed_exc_e access_verdict(
    input logic       feat,
    input logic       wr,
    input logic [1:0] priv,
    input logic       virt,
    input logic       s_en,
    input logic       u_en
  );
    if (!feat)                      return EXC_ILLEGAL;
    if (!wr)                        return EXC_ILLEGAL;
    if (virt && priv != PRIV_M)     return s_en ? EXC_VIRT : EXC_ILLEGAL;
    if (priv == PRIV_M)             return EXC_NONE;
    if (priv == PRIV_S && s_en)     return EXC_NONE;
    if (priv == PRIV_U && u_en)     return EXC_NONE;
    return EXC_ILLEGAL;
  endfunction

  // Assemble the read word; the sample is only visible with a ready status.
  function automatic logic [31:0] pack_word(input seed_stat_e st, input logic [15:0] smp);
    logic [15:0] low;
    low = (st == ST_READY) ? smp : 16'h0000;
    return {st, 14'b0, low};
  endfunction

endpackage

// File: rtl/seed_access_check.sv
module seed_access_check
  import seed_csr_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] SEED_ADDR = 12'h015
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              feat_en_i,
  input  logic              wr_intent_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic              sup_en_i,
  input  logic              usr_en_i,
  output logic              hit_o,
  output logic              grant_o,
  output seed_exc_e         exc_o
);

  seed_exc_e verdict;

  always_comb begin
    hit_o   = req_i && (addr_i == ADDR_W'(SEED_ADDR));
    verdict = access_verdict(feat_en_i, wr_intent_i, priv_i, virt_i, sup_en_i, usr_en_i);
    exc_o   = hit_o ? verdict : EXC_NONE;
    grant_o = hit_o && (verdict == EXC_NONE);
  end

  assert_pure_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !wr_intent_i |-> exc_o == EXC_ILLEGAL && !grant_o);

  assert_virt_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && feat_en_i && wr_intent_i && virt_i && priv_i != PRIV_M |-> !grant_o);

  assert_machine_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && feat_en_i && wr_intent_i && priv_i == PRIV_M |-> grant_o);

  assert_miss_silent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> exc_o == EXC_NONE && !grant_o);

endmodule

// File: rtl/seed_health.sv
module seed_health
  import seed_csr_pkg::*;
#(
  parameter int SELFTEST_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fail_i,
  input  logic       buf_full_i,
  output seed_stat_e stat_o,
  output logic       run_o,
  output logic       dead_o
);

  localparam int CNT_W = $clog2(SELFTEST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             dead_q;
  logic             selftest_done;

  assign selftest_done = (cnt_q == CNT_W'(SELFTEST_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      dead_q <= 1'b0;
    end else begin
      dead_q <= dead_q | fail_i;
      if (!run_q) begin
        if (selftest_done) run_q <= 1'b1;
        else               cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (dead_q)          stat_o = ST_FAILED;
    else if (!run_q)     stat_o = ST_SELFTEST;
    else if (buf_full_i) stat_o = ST_READY;
    else                 stat_o = ST_WAIT;
  end

  assign run_o  = run_q;
  assign dead_o = dead_q;

  assert_dead_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> dead_o && stat_o == ST_FAILED);

  assert_fail_reacts_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> stat_o == ST_FAILED);

  assert_selftest_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o == ST_SELFTEST && !fail_i |=> stat_o == ST_SELFTEST || stat_o == ST_WAIT);

endmodule

// File: rtl/seed_sample_buf.sv
module seed_sample_buf #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_en_i,
  input  logic                flush_i,
  input  logic                consume_i,
  input  logic                src_valid_i,
  input  logic [SAMPLE_W-1:0] src_data_i,
  output logic                src_ready_o,
  output logic                full_o,
  output logic [SAMPLE_W-1:0] data_o
);

  logic                full_q;
  logic [SAMPLE_W-1:0] data_q;
  logic                capture;

  assign src_ready_o = accept_en_i && !full_q;
  assign capture     = src_ready_o && src_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (flush_i || consume_i) begin
      full_q <= 1'b0;
    end else if (capture) begin
      full_q <= 1'b1;
      data_q <= src_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  assert_single_use_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !full_o);

  assert_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !consume_i && !flush_i |=> full_o && $stable(data_o));

  assert_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture && !flush_i |=> full_o && data_o == $past(src_data_i));

endmodule

// File: rtl/entropy_seed_csr.sv
module entropy_seed_csr
  import seed_csr_pkg::*;
#(
  parameter int SELFTEST_CYCLES = 16,
  parameter int SAMPLE_W        = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                feat_en_i,
  input  logic                req_i,
  input  logic [11:0]         addr_i,
  input  logic                wr_intent_i,
  input  logic [1:0]          priv_i,
  input  logic                virt_i,
  input  logic                sup_seed_en_i,
  input  logic                usr_seed_en_i,
  output logic                hit_o,
  output logic [1:0]          exc_o,
  output logic [31:0]         rdata_o,
  input  logic                src_valid_i,
  input  logic [SAMPLE_W-1:0] src_data_i,
  output logic                src_ready_o,
  input  logic                src_fail_i
);

  seed_exc_e           exc;
  seed_stat_e          stat;
  logic                grant;
  logic                consume;
  logic                run;
  logic                dead;
  logic                buf_full;
  logic [SAMPLE_W-1:0] buf_data;

  seed_access_check u_check (
    .clk_i, .rst_ni, .req_i, .addr_i, .feat_en_i, .wr_intent_i,
    .priv_i, .virt_i,
    .sup_en_i (sup_seed_en_i),
    .usr_en_i (usr_seed_en_i),
    .hit_o,
    .grant_o  (grant),
    .exc_o    (exc)
  );

  seed_health #(.SELFTEST_CYCLES(SELFTEST_CYCLES)) u_health (
    .clk_i, .rst_ni,
    .fail_i     (src_fail_i),
    .buf_full_i (buf_full),
    .stat_o     (stat),
    .run_o      (run),
    .dead_o     (dead)
  );

  assign consume = grant && (stat == ST_READY);

  seed_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk_i, .rst_ni,
    .accept_en_i (run && !dead),
    .flush_i     (dead),
    .consume_i   (consume),
    .src_valid_i, .src_data_i, .src_ready_o,
    .full_o      (buf_full),
    .data_o      (buf_data)
  );

  assign exc_o   = exc;
  assign rdata_o = grant ? pack_word(stat, 16'(buf_data)) : 32'h0;

  assert_zero_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:30] != 2'b10 |-> rdata_o[15:0] == 16'h0);

  assert_exc_no_consume_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && exc_o != 2'd0 && buf_full && !dead |=> buf_full);

  assert_ready_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> stat == ST_WAIT);

endmodule

// File: tb/entropy_seed_csr_tb_top.sv
`timescale 1ns/1ps
module entropy_seed_csr_tb_top;

  localparam int ST = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_en = 1'b1, req = 1'b0, wr = 1'b1, virt = 1'b0;
  logic        s_en = 1'b0, u_en = 1'b0;
  logic [11:0] addr = 12'h015;
  logic [1:0]  priv = 2'b11;
  logic        hit;
  logic [1:0]  exc;
  logic [31:0] rdata;
  logic        src_valid = 1'b0, src_ready, src_fail = 1'b0;
  logic [15:0] src_data = 16'h0;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic        g_hit;
  logic [1:0]  g_exc;
  logic [31:0] g_rd;

  always #2.5 clk = ~clk;

  entropy_seed_csr #(.SELFTEST_CYCLES(ST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .feat_en_i(feat_en), .req_i(req), .addr_i(addr),
    .wr_intent_i(wr), .priv_i(priv), .virt_i(virt), .sup_seed_en_i(s_en),
    .usr_seed_en_i(u_en), .hit_o(hit), .exc_o(exc), .rdata_o(rdata),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .src_fail_i(src_fail)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [1:0] st, input logic [15:0] d);
    return {st, 14'b0, (st == 2'b10) ? d : 16'h0};
  endfunction

  task automatic access(input logic [11:0] a, input logic w, input logic [1:0] p,
                        input logic v, input logic se, input logic ue, input logic fe);
    @(negedge clk);
    addr = a; wr = w; priv = p; virt = v; s_en = se; u_en = ue; feat_en = fe; req = 1'b1;
    #1;
    g_hit = hit; g_exc = exc; g_rd = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic mread();
    access(12'h015, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic feed(input logic [15:0] d);
    @(negedge clk);
    src_valid = 1'b1; src_data = d;
    while (!src_ready) @(negedge clk);
    @(posedge clk); #1;
    src_valid = 1'b0;
  endtask

  task automatic t_selftest();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R9 ready low in self-test", {31'b0, src_ready}, 32'h0);
    repeat (ST - 1) @(posedge clk);
    @(negedge clk); req = 1'b1; addr = 12'h015; wr = 1'b1; priv = 2'b11; #1;
    chk("R9 status 00 at last self-test edge", rdata, word(2'b00, 16'h0));
    @(negedge clk); #1;
    chk("R9 status 01 after self-test", rdata, word(2'b01, 16'h0));
    chk("R10 ready high when idle", {31'b0, src_ready}, 32'h1);
    req = 1'b0;
  endtask

  task automatic t_consume();
    feed(16'hBEEF);
    chk("R10 ready low when full", {31'b0, src_ready}, 32'h0);
    mread();
    chk("R2 R3 sample read", g_rd, word(2'b10, 16'hBEEF));
    chk("R5 machine no exception", {30'b0, g_exc}, 32'h0);
    mread();
    chk("R11 consumed, waiting", g_rd, word(2'b01, 16'h0));
    feed(16'h0001);
    mread();
    chk("R11 refill read", g_rd, word(2'b10, 16'h0001));
  endtask

  task automatic t_perm();
    feed(16'hA5A5);
    access(12'h015, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R8 feature off", {30'b0, g_exc}, 32'd1);
    access(12'h015, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R4 pure read illegal", {30'b0, g_exc}, 32'd1);
    chk("R3 exception zero data", g_rd, 32'h0);
    access(12'h015, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 supervisor disabled", {30'b0, g_exc}, 32'd1);
    access(12'h015, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R6 user disabled", {30'b0, g_exc}, 32'd1);
    access(12'h015, 1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6 reserved mode", {30'b0, g_exc}, 32'd1);
    access(12'h015, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R7 virtual supervisor fault", {30'b0, g_exc}, 32'd2);
    access(12'h015, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R7 virtual user illegal", {30'b0, g_exc}, 32'd1);
    access(12'h015, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R4 pure read before virtual check", {30'b0, g_exc}, 32'd1);
    access(12'h015, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R13 R6 user grant keeps sample", g_rd, word(2'b10, 16'hA5A5));
    feed(16'h1234);
    access(12'h015, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R6 supervisor grant", g_rd, word(2'b10, 16'h1234));
    feed(16'h8001);
    access(12'h015, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R5 virtual machine grant", g_rd, word(2'b10, 16'h8001));
  endtask

  task automatic t_addr();
    feed(16'h5A5A);
    access(12'h016, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 miss hit", {31'b0, g_hit}, 32'h0);
    chk("R1 miss exception", {30'b0, g_exc}, 32'h0);
    chk("R1 miss data", g_rd, 32'h0);
    access(12'h115, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1 alias miss", {31'b0, g_hit}, 32'h0);
    mread();
    chk("R1 sample untouched", g_rd, word(2'b10, 16'h5A5A));
  endtask

  task automatic t_fail();
    feed(16'h7777);
    @(negedge clk); src_fail = 1'b1;
    @(posedge clk); #1; src_fail = 1'b0;
    mread();
    chk("R12 failed status", g_rd, word(2'b11, 16'h0));
    repeat (5) @(posedge clk);
    @(negedge clk); src_valid = 1'b1; src_data = 16'hFFFF; #1;
    chk("R12 ready stays low", {31'b0, src_ready}, 32'h0);
    @(posedge clk); #1; src_valid = 1'b0;
    mread();
    chk("R12 sticky after input drops", g_rd, word(2'b11, 16'h0));
  endtask

  initial begin
    t_selftest();
    t_consume();
    t_perm();
    t_addr();
    t_fail();
    summary();
  end

endmodule